// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This core moves bytes between time-division multiplexed streams. A number of input streams arrive in parallel, one byte per stream in each time slot. Every byte is stored in a data memory indexed by stream and channel. In the same slot, each output stream produces one byte. That byte is chosen by a per-output connection word, which is held in a connection memory that the host programs through a simple write port.

A connection word can route a byte from any input stream and channel, in one of two timings. In variable-delay mode the source is taken from the current frame whenever it has already arrived. In constant-delay mode the source always comes from the previous frame. A connection word can instead send a fixed message byte that it carries itself, or a byte drawn from a shared pseudo-random generator for line testing.

The data memory is double-buffered. Its two banks exchange roles at each frame pulse. Stream and channel counts are parameters and must be powers of two, with at least two streams and at most 256 channels.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `outBytes` is all zeros and `outFrameSync` is 0. Reset also clears every connection word and every data-memory byte to zero.
- R2: A high `frameSync` marks the current input slot as channel 0. Without it, the slot number counts up by one per clock and wraps from NUM_CHANNELS-1 to 0. The output byte for slot c appears on the clock after slot c is presented. `outFrameSync` is high exactly on the clock after a `frameSync`.
- R3: Connection word layout: bits [15:14] hold the mode, bits [12:8] hold the source stream and bits [7:0] hold the source channel. Only the low log2(NUM_STREAMS) bits of the stream field and the low log2(NUM_CHANNELS) bits of the channel field are used. Bit 13 is ignored.
- R4: Mode encoding in bits [15:14]: 00 is variable-delay switching, 10 is constant-delay switching, 01 is message and 11 is test pattern.
- R5: In constant-delay mode, the output byte equals the byte that the named source stream and channel received in the previous frame.
- R6: In variable-delay mode, a source channel lower than the output slot yields the byte received in the current frame. Any other source channel yields the byte from the previous frame.
- R7: In message mode, the output byte is bits [7:0] of the connection word.
- R8: Test pattern: a 15-bit register s is seeded to PRBS_SEED (default 1) at reset. One step computes f = s[14] XOR s[13] and sets s = {s[13:0], f}, and f is the output bit. A test-mode output takes 8 steps, and its byte is assembled most significant bit first. Within one slot, test-mode streams are served in ascending stream order. The state is held when no stream is in test mode.
- R9: A connection write takes effect from the next clock. A read of the same entry in the write's own clock still sees the old word.
- R10: The two data-memory banks exchange roles only on `frameSync`. A frame that runs longer than NUM_CHANNELS slots without a pulse keeps writing the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Marks the current slot as channel 0 |
| inBytes | input | NUM_STREAMS*8 | Input bytes, stream s in bits [8s+7:8s] |
| cmWrEn | input | 1 | Connection memory write enable |
| cmWrStream | input | log2(NUM_STREAMS) | Output stream of the entry written |
| cmWrChan | input | log2(NUM_CHANNELS) | Output channel of the entry written |
| cmWrData | input | 16 | Connection word written |
| outBytes | output | NUM_STREAMS*8 | Output bytes for the previous slot, stream s in bits [8s+7:8s] |
| outFrameSync | output | 1 | High while `outBytes` carries channel 0 |

## Verification
The all-zero connection memory after reset routes every output from stream 0 channel 0 in variable mode. Slot 0 therefore shows the previous frame and every later slot shows the current frame, which separates the two bank choices. A reversed-channel constant map is then checked against a shifted-channel variable map, and only the variable map mixes frames inside one output frame. Message and test outputs are interleaved across streams so that the order of generator steps is visible. Short and long frames, and a rewrite of the entry being read, expose bank-swap and write-timing mistakes.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  localparam int CM_WORD_W = 16;
  localparam int LFSR_W    = 15;

  typedef enum logic [1:0] {
    MODE_VAR   = 2'b00,
    MODE_MSG   = 2'b01,
    MODE_CONST = 2'b10,
    MODE_PRBS  = 2'b11
  } tsw_mode_e;

  // Strobes from control to datapath for the current slot.
  typedef struct packed {
    logic [7:0] slot;      // current input channel number
    logic       bank;      // data-memory bank written this frame
    logic       newFrame;  // this slot begins a frame
  } tsw_strobe_t;

  // One step of the x^15 + x^14 + 1 generator; new bit enters at bit 0.
  function automatic logic [LFSR_W-1:0] prbsStep(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[14] ^ s[13]};
  endfunction

endpackage

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int NUM_CHANNELS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  output tsw_strobe_t strb
);

  localparam int CW = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1;
  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CHANNELS - 1);

  logic [CW-1:0] slotQ, slotD;
  logic          bankQ, bankD;

  always_comb begin
    if (frameSync)             slotD = '0;
    else if (slotQ == LAST_CH) slotD = '0;
    else                       slotD = slotQ + 1'b1;
    bankD = frameSync ? ~bankQ : bankQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= LAST_CH;
      bankQ <= 1'b0;
    end else begin
      slotQ <= slotD;
      bankQ <= bankD;
    end
  end

  always_comb begin
    strb              = '0;
    strb.slot[CW-1:0] = slotD;
    strb.bank         = bankD;
    strb.newFrame     = frameSync;
  end

endmodule

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
#(
  parameter int                NUM_STREAMS  = 4,
  parameter int                NUM_CHANNELS = 8,
  parameter logic [LFSR_W-1:0] PRBS_SEED    = 15'h0001
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tsw_strobe_t                   strb,
  input  logic [NUM_STREAMS*8-1:0]      inBytes,
  input  logic                          cmWrEn,
  input  logic [$clog2(NUM_STREAMS)-1:0] cmWrStream,
  input  logic [$clog2(NUM_CHANNELS)-1:0] cmWrChan,
  input  logic [CM_WORD_W-1:0]          cmWrData,
  output logic [NUM_STREAMS*8-1:0]      outBytes,
  output logic                          outFrameSync
);

  localparam int SW = $clog2(NUM_STREAMS);
  localparam int CW = $clog2(NUM_CHANNELS);

  logic [7:0]           dmem [2][NUM_STREAMS][NUM_CHANNELS];
  logic [CM_WORD_W-1:0] cmem [NUM_STREAMS][NUM_CHANNELS];

  logic [CW-1:0] slotIdx;
  logic [7:0]    slotUnused;
  assign slotIdx    = strb.slot[CW-1:0];
  assign slotUnused = strb.slot;

  // Data memory: every stream writes its byte into the active bank.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NUM_STREAMS; s++)
          for (int c = 0; c < NUM_CHANNELS; c++)
            dmem[b][s][c] <= '0;
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++)
        dmem[strb.bank][s][slotIdx] <= inBytes[s*8 +: 8];
    end
  end

  // Connection memory.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++)
        for (int c = 0; c < NUM_CHANNELS; c++)
          cmem[s][c] <= '0;
    end else if (cmWrEn) begin
      cmem[cmWrStream][cmWrChan] <= cmWrData;
    end
  end

  tsw_mode_e  modeArr [NUM_STREAMS];
  logic [7:0] swArr   [NUM_STREAMS];
  logic [7:0] msgArr  [NUM_STREAMS];

  // Per-stream decode of the connection word and switched-byte fetch.
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_str
    logic [CM_WORD_W-1:0] word;
    tsw_mode_e            mode;
    logic [SW-1:0]        srcS;
    logic [CW-1:0]        srcC;
    logic                 rdBank;
    logic                 wordUnused;

    assign word       = cmem[s][slotIdx];
    assign mode       = tsw_mode_e'(word[15:14]);
    assign srcS       = word[8 +: SW];
    assign srcC       = word[0 +: CW];
    assign wordUnused = ^word;

    // Variable mode takes the current bank only for already-arrived sources.
    assign rdBank = (mode == MODE_VAR && srcC < slotIdx) ? strb.bank : ~strb.bank;

    assign modeArr[s] = mode;
    assign swArr[s]   = dmem[rdBank][srcS][srcC];
    assign msgArr[s]  = word[7:0];
  end

  logic [LFSR_W-1:0] lfsrQ, lfsrNext;
  logic [7:0]        selArr [NUM_STREAMS];

  // Output selection; the generator is chained across streams in index order.
  always_comb begin
    lfsrNext = lfsrQ;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      selArr[s] = swArr[s];
      case (modeArr[s])
        MODE_MSG: selArr[s] = msgArr[s];
        MODE_PRBS: begin
          for (int b = 0; b < 8; b++) begin
            lfsrNext = prbsStep(lfsrNext);
            selArr[s][3'(7 - b)] = lfsrNext[0];
          end
        end
        default: selArr[s] = swArr[s];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ        <= PRBS_SEED;
      outBytes     <= '0;
      outFrameSync <= 1'b0;
    end else begin
      lfsrQ        <= lfsrNext;
      outFrameSync <= strb.newFrame;
      for (int s = 0; s < NUM_STREAMS; s++)
        outBytes[s*8 +: 8] <= selArr[s];
    end
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsw_pkg::*;
#(
  parameter int          NUM_STREAMS  = 4,
  parameter int          NUM_CHANNELS = 8,
  parameter logic [14:0] PRBS_SEED    = 15'h0001
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            frameSync,
  input  logic [NUM_STREAMS*8-1:0]        inBytes,
  input  logic                            cmWrEn,
  input  logic [$clog2(NUM_STREAMS)-1:0]  cmWrStream,
  input  logic [$clog2(NUM_CHANNELS)-1:0] cmWrChan,
  input  logic [15:0]                     cmWrData,
  output logic [NUM_STREAMS*8-1:0]        outBytes,
  output logic                            outFrameSync
);

  tsw_strobe_t strb;

  tsw_ctrl #(
    .NUM_CHANNELS(NUM_CHANNELS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .strb     (strb)
  );

  tsw_datapath #(
    .NUM_STREAMS (NUM_STREAMS),
    .NUM_CHANNELS(NUM_CHANNELS),
    .PRBS_SEED   (PRBS_SEED)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inBytes     (inBytes),
    .cmWrEn      (cmWrEn),
    .cmWrStream  (cmWrStream),
    .cmWrChan    (cmWrChan),
    .cmWrData    (cmWrData),
    .outBytes    (outBytes),
    .outFrameSync(outFrameSync)
  );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsw_pkg::*;
#(
  parameter int NUM_STREAMS  = 4,
  parameter int NUM_CHANNELS = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input tsw_strobe_t                strb,
  input logic [NUM_STREAMS*8-1:0]   outBytes,
  input logic                       outFrameSync
);

  localparam logic [7:0] LAST_CH = 8'(NUM_CHANNELS - 1);

  logic bankPrev, prevValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankPrev  <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      bankPrev  <= strb.bank;
      prevValid <= 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (outBytes == '0 && !outFrameSync)); // R1

  AST_FRAME_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    strb.newFrame |=> outFrameSync); // R2

  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.newFrame |=> !outFrameSync); // R2

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.slot <= LAST_CH); // R2

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slot == LAST_CH) |=> strb.slot == 8'd0); // R2

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slot != LAST_CH) ##1 !strb.newFrame |-> strb.slot == $past(strb.slot) + 8'd1); // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && !strb.newFrame) |-> strb.bank == bankPrev); // R10

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && strb.newFrame) |-> strb.bank != bankPrev); // R10

endmodule

bind tsi_switch tsi_switch_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .NUM_CHANNELS(NUM_CHANNELS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strb        (strb),
  .outBytes    (outBytes),
  .outFrameSync(outFrameSync)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;

  localparam int NS = 4;
  localparam int NC = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameSync = 1'b0;
  logic [NS*8-1:0]   inBytes = '0;
  logic              cmWrEn = 1'b0;
  logic [1:0]        cmWrStream = '0;
  logic [2:0]        cmWrChan = '0;
  logic [15:0]       cmWrData = '0;
  logic [NS*8-1:0]   outBytes;
  logic              outFrameSync;

  always #10 clk = ~clk;

  tsi_switch #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) u_tsi_switch (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inBytes(inBytes),
    .cmWrEn(cmWrEn), .cmWrStream(cmWrStream), .cmWrChan(cmWrChan),
    .cmWrData(cmWrData), .outBytes(outBytes), .outFrameSync(outFrameSync)
  );

  int checks = 0;
  int errors = 0;
  bit timedOut = 0;

  // Reference state, built from the requirements.
  logic [7:0]  mDm [2][NS][NC];
  logic [15:0] mCm [NS][NC];
  logic        mBank = 1'b0;
  int          mSlot = NC - 1;
  int          frameNo = 0;
  logic [14:0] mLfsr = 15'h0001;

  typedef struct {
    logic [NS*8-1:0] bytes;
    logic            fs;
    bit              chk;
    string           req;
  } exp_t;
  exp_t expQ[$];

  function automatic logic [15:0] cmWord(input logic [1:0] mode, input logic [4:0] st, input logic [7:0] ch);
    return {mode, 1'b0, st, ch};
  endfunction

  function automatic logic [7:0] srcByte(input int fr, input int s, input int c);
    return 8'(((fr & 3) << 6) | (s << 3) | c);
  endfunction

  // Drive one slot and push the reference result.
  task automatic slot(input bit fs, input bit we, input int ws, input int wc,
                      input logic [15:0] wd, input bit chk, input string req);
    exp_t e;
    int cur;
    logic bank;
    logic [NS*8-1:0] din;
    @(negedge clk);
    cur  = fs ? 0 : ((mSlot == NC - 1) ? 0 : mSlot + 1);
    bank = fs ? ~mBank : mBank;
    if (fs) frameNo++;
    for (int s = 0; s < NS; s++) din[s*8 +: 8] = srcByte(frameNo, s, cur);
    for (int s = 0; s < NS; s++) begin
      logic [15:0] w;
      int ss, sc;
      logic [7:0] r;
      w  = mCm[s][cur];
      ss = int'(w[9:8]);
      sc = int'(w[2:0]);
      case (w[15:14])
        2'b00: r = (sc < cur) ? mDm[bank][ss][sc] : mDm[~bank][ss][sc];
        2'b10: r = mDm[~bank][ss][sc];
        2'b01: r = w[7:0];
        default: begin
          for (int b = 7; b >= 0; b--) begin
            logic f;
            f = mLfsr[14] ^ mLfsr[13];
            mLfsr = {mLfsr[13:0], f};
            r[b] = f;
          end
        end
      endcase
      e.bytes[s*8 +: 8] = r;
    end
    e.fs = fs; e.chk = chk; e.req = req;
    expQ.push_back(e);
    for (int s = 0; s < NS; s++) mDm[bank][s][cur] = din[s*8 +: 8];
    if (we) mCm[ws][wc] = wd;
    mSlot = cur; mBank = bank;
    frameSync  = fs;
    inBytes    = din;
    cmWrEn     = we;
    cmWrStream = 2'(ws);
    cmWrChan   = 3'(wc);
    cmWrData   = wd;
  endtask

  task automatic frames(input int n, input string req);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < NC; c++) slot(c == 0, 1'b0, 0, 0, 16'h0, 1'b1, req);
  endtask

  // Write one connection word while frames keep running, results unchecked.
  task automatic cfg(input int ws, input int wc, input logic [15:0] wd);
    slot(mSlot == NC - 1, 1'b1, ws, wc, wd, 1'b0, "cfg");
  endtask

  // Monitor: compares one queued item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        if (e.chk) begin
          checks++;
          if (outBytes !== e.bytes || outFrameSync !== e.fs) begin
            errors++;
            $display("FAIL %s: outBytes=%h outFrameSync=%b expected %h %b",
                     e.req, outBytes, outFrameSync, e.bytes, e.fs);
          end
        end
      end
    end
  end

  task automatic runAll();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NC; c++) mDm[b][s][c] = '0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) mCm[s][c] = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (outBytes !== '0 || outFrameSync !== 1'b0) begin
      errors++;
      $display("FAIL R1: outBytes=%h outFrameSync=%b expected 0 0", outBytes, outFrameSync);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R6, R2: all-zero words route stream 0 channel 0 in variable mode
    frames(3, "R6 default map");

    // R5, R3, R4: constant mode, reversed channels, rotated streams;
    // stream 3 entries also set bit 13 and high field bits
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        logic [15:0] w;
        w = cmWord(2'b10, 5'((s + 1) % NS), 8'(NC - 1 - c));
        if (s == 3) w = w | 16'h2000 | 16'h1400 | 16'h00F8;
        cfg(s, c, w);
      end
    frames(3, "R5 R3 R4 constant map");

    // R6: variable mode, shifted channels mix current and previous frame
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        cfg(s, c, cmWord(2'b00, 5'(s), 8'((c + 3) % NC)));
    frames(3, "R6 variable map");

    // R7, R8: message on streams 0 and 2, test pattern on 1 and 3
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        cfg(s, c, (s % 2 == 0) ? cmWord(2'b01, 5'(s), 8'(8'hA0 + s * 16 + c))
                               : cmWord(2'b11, 5'h0, 8'h0));
    frames(2, "R7 R8 message and pattern");

    // R8: all streams in test mode, longest chain
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) cfg(s, c, cmWord(2'b11, 5'h0, 8'h0));
    frames(2, "R8 full pattern");

    // R9: rewrite the entry being read in the same clock
    for (int c = 0; c < NC; c++) cfg(0, c, cmWord(2'b01, 5'h0, 8'h11));
    for (int c = 0; c < NC; c++)
      slot(c == 0, c == 5, 0, 5, cmWord(2'b01, 5'h0, 8'h55), 1'b1, "R9 same-clock write");
    frames(1, "R9 after write");

    // R2, R10: short frame and long frame under a constant map
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) cfg(s, c, cmWord(2'b10, 5'(s), 8'(c)));
    frames(2, "R5 identity");
    for (int c = 0; c < 5; c++) slot(c == 0, 1'b0, 0, 0, 16'h0, 1'b1, "R2 R10 short frame");
    for (int c = 0; c < 12; c++) slot(c == 0, 1'b0, 0, 0, 16'h0, 1'b1, "R2 R10 long frame");
    frames(2, "R10 recovery");

    @(negedge clk);
    frameSync = 1'b0;
    cmWrEn = 1'b0;
    repeat (3) @(posedge clk);
    #4;
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule